// File: doc/BRIEF.md
# Interrupt Priority Elevation Controller

This block raises a high-priority request toward a bus crossbar arbiter while one processor is servicing a critical or external interrupt. It watches both interrupt request lines and qualifies each with the processor's own interrupt-enable flag for that class. A per-class elevation-enable bit decides whether a newly detected interrupt starts an elevation. The request stays up for the whole service routine. It ends only when a 4-bit processor status code reports a return-from-interrupt.

A critical interrupt can preempt an external service routine. A small nesting counter tracks this, so the request falls only after the outermost routine returns. All control pins are plain level signals. The block has no data stream and therefore no valid/ready handshake. The single output is registered and goes straight to the arbiter.

Top module: `irq_elev_ctrl`

## Requirements
- R1: A synchronous active-low reset sets the output low, empties the nesting count and clears the stored request levels. A request held high through reset is therefore seen as new on the first cycle after release.
- R2: A critical detection is a rising edge of (crit_irq AND crit_en). When the block is idle and crit_elev_en is 1, this detection raises hi_pri on the clock edge that samples it.
- R3: An external detection is a rising edge of (ext_irq AND ext_en). When the block is idle and ext_elev_en is 1, it raises hi_pri in the same way.
- R4: From idle, hi_pri stays low unless a detection of some class arrives together with that class's elevation-enable bit set. A request whose processor enable flag is low is never detected.
- R5: Once high, hi_pri stays high for every status code other than 4'b1010, whatever the request lines do.
- R6: Status code 4'b1010 means return-from-interrupt. When the nesting count is 1, this code drops hi_pri at the edge that samples it. When the block is idle, the code has no effect.
- R7: When critical and external detections arrive in the same idle cycle, critical wins. The external detection is discarded, so one return ends the elevation.
- R8: During external service, a critical detection nests and increments the count; crit_elev_en is not needed for this. If a return arrives in the same cycle, the two cancel. hi_pri falls only when the count reaches zero.
- R9: During critical service, new detections of either class are ignored. During external service, new external detections are ignored.
- R10: Clearing an elevation-enable bit while elevated does not lower hi_pri. It only blocks later elevations from idle.
- R11: A request held high causes only one detection. It does not re-elevate after its return until it goes low and rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| crit_irq | input | 1 | Critical interrupt request line |
| ext_irq | input | 1 | External interrupt request line from the interrupt controller |
| crit_en | input | 1 | Processor flag enabling critical interrupt servicing |
| ext_en | input | 1 | Processor flag enabling external interrupt servicing |
| crit_elev_en | input | 1 | Allow elevation on critical interrupts |
| ext_elev_en | input | 1 | Allow elevation on external interrupts |
| pstat | input | PSTAT_W | Processor status code; RFI_CODE (4'b1010) marks return-from-interrupt |
| hi_pri | output | 1 | High-priority request to the crossbar arbiter |

## Verification
The bench targets the following cases, each of which catches a specific design error:
- Simultaneous critical and external detections: a design that let external win would need an extra return before dropping.
- A critical interrupt nested in an external routine: a design that dropped after the first return would release the arbiter early.
- A return and a nested detection in the same cycle: a design that ignored either one would stay elevated forever or fall too soon.
- Request lines held high across a return, and a request held through reset: these expose a level-sensitive detector, which would re-elevate, and a detector that keeps stale history across reset.
- Enable bits cleared while elevated: a design that dropped hi_pri here would cut a service routine short.

// File: rtl/irq_elev_pkg.sv
package irq_elev_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CRIT = 2'd1,
    ST_EXT  = 2'd2
  } elev_state_e;

  localparam int NUM_SRC  = 2;
  localparam int SRC_CRIT = 0;
  localparam int SRC_EXT  = 1;
endpackage

// File: rtl/irq_elev_edge.sv
// Per-source qualified rising-edge detector.
module irq_elev_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic [N-1:0] en,
  output logic [N-1:0] det
);
  for (genvar i = 0; i < N; i++) begin : g_src
    logic qual;
    logic prev_q;
    assign qual = req[i] & en[i];
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= qual;
    end
    assign det[i] = qual & ~prev_q;
  end
endmodule

// File: rtl/irq_elev_rfi_dec.sv
// Decodes the processor status code for a return-from-interrupt.
module irq_elev_rfi_dec #(
  parameter int                 PSTAT_W  = 4,
  parameter logic [PSTAT_W-1:0] RFI_CODE = 4'b1010
) (
  input  logic [PSTAT_W-1:0] pstat,
  output logic               rfi
);
  assign rfi = (pstat == RFI_CODE);
endmodule

// File: rtl/irq_elev_fsm.sv
// Elevation state machine with nesting counter.
module irq_elev_fsm
  import irq_elev_pkg::*;
#(
  parameter int DEPTH_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               det_crit,
  input  logic               det_ext,
  input  logic               crit_elev_en,
  input  logic               ext_elev_en,
  input  logic               rfi,
  output elev_state_e        state_q,
  output logic [DEPTH_W-1:0] depth_q,
  output logic               hi_pri_q
);
  localparam logic [DEPTH_W-1:0] DEPTH_MAX = {DEPTH_W{1'b1}};
  localparam logic [DEPTH_W-1:0] DEPTH_ONE = {{(DEPTH_W-1){1'b0}}, 1'b1};

  logic               inc, dec;
  elev_state_e        target, state_n;
  logic [DEPTH_W-1:0] depth_n;

  always_comb begin
    inc    = 1'b0;
    target = state_q;
    dec    = rfi && (depth_q != '0);
    unique case (state_q)
      ST_IDLE: begin
        if (det_crit && crit_elev_en) begin
          inc    = 1'b1;
          target = ST_CRIT;
        end else if (det_ext && ext_elev_en) begin
          inc    = 1'b1;
          target = ST_EXT;
        end
      end
      ST_EXT: begin
        if (det_crit && (depth_q != DEPTH_MAX)) begin
          inc    = 1'b1;
          target = ST_CRIT;
        end
      end
      default: ;
    endcase

    depth_n = depth_q;
    if (inc && !dec)      depth_n = depth_q + DEPTH_ONE;
    else if (dec && !inc) depth_n = depth_q - DEPTH_ONE;

    if (depth_n == '0)               state_n = ST_IDLE;
    else if (inc)                    state_n = target;
    else if (dec && state_q == ST_CRIT) state_n = ST_EXT;
    else                             state_n = state_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      depth_q  <= '0;
      hi_pri_q <= 1'b0;
    end else begin
      state_q  <= state_n;
      depth_q  <= depth_n;
      hi_pri_q <= (depth_n != '0);
    end
  end
endmodule

// File: rtl/irq_elev_ctrl.sv
module irq_elev_ctrl
  import irq_elev_pkg::*;
#(
  parameter int                 PSTAT_W  = 4,
  parameter logic [PSTAT_W-1:0] RFI_CODE = 4'b1010,
  parameter int                 DEPTH_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               crit_irq,
  input  logic               ext_irq,
  input  logic               crit_en,
  input  logic               ext_en,
  input  logic               crit_elev_en,
  input  logic               ext_elev_en,
  input  logic [PSTAT_W-1:0] pstat,
  output logic               hi_pri
);
  logic [NUM_SRC-1:0] req, en, det;
  logic               rfi;
  elev_state_e        state_q;
  logic [DEPTH_W-1:0] depth_q;

  assign req[SRC_CRIT] = crit_irq;
  assign req[SRC_EXT]  = ext_irq;
  assign en[SRC_CRIT]  = crit_en;
  assign en[SRC_EXT]   = ext_en;

  irq_elev_edge #(.N(NUM_SRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .req(req), .en(en), .det(det)
  );

  irq_elev_rfi_dec #(.PSTAT_W(PSTAT_W), .RFI_CODE(RFI_CODE)) u_rfi (
    .pstat(pstat), .rfi(rfi)
  );

  irq_elev_fsm #(.DEPTH_W(DEPTH_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .det_crit(det[SRC_CRIT]), .det_ext(det[SRC_EXT]),
    .crit_elev_en(crit_elev_en), .ext_elev_en(ext_elev_en),
    .rfi(rfi), .state_q(state_q), .depth_q(depth_q), .hi_pri_q(hi_pri)
  );
endmodule

// File: rtl/irq_elev_ctrl_chk.sv
module irq_elev_ctrl_chk #(
  parameter int                 PSTAT_W  = 4,
  parameter logic [PSTAT_W-1:0] RFI_CODE = 4'b1010,
  parameter int                 DEPTH_W  = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               crit_irq,
  input logic               ext_irq,
  input logic               crit_en,
  input logic               ext_en,
  input logic               crit_elev_en,
  input logic               ext_elev_en,
  input logic [PSTAT_W-1:0] pstat,
  input logic               hi_pri,
  input logic [1:0]         state_q,
  input logic [DEPTH_W-1:0] depth_q
);
  logic rst_seen_q;
  always_ff @(posedge clk) begin
    rst_seen_q <= !rst_n;
    if (rst_seen_q) begin
      a_r1_reset: assert (!hi_pri) else $error("R1 hi_pri high after reset");
    end
  end

  // R5: hold without a return code
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_pri && pstat != RFI_CODE) |=> hi_pri);

  // R6: falls only after a return code or reset
  a_r6_fall_on_rfi: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hi_pri) |-> ($past(pstat) == RFI_CODE || !$past(rst_n)));

  // R4: from idle, nothing elevates without a qualified enabled request
  a_r4_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_pri && !(crit_irq && crit_en && crit_elev_en)
             && !(ext_irq && ext_en && ext_elev_en)) |=> !hi_pri);

  // R8: output mirrors a nonzero nesting count
  a_r8_depth: assert property (@(posedge clk) disable iff (!rst_n)
    hi_pri == (depth_q != '0));

  // R9: critical service never returns to idle without a return code
  a_r9_crit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == 2'd1 && pstat != RFI_CODE) |=> (state_q == 2'd1));
endmodule

bind irq_elev_ctrl irq_elev_ctrl_chk #(
  .PSTAT_W(PSTAT_W), .RFI_CODE(RFI_CODE), .DEPTH_W(DEPTH_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .crit_irq(crit_irq), .ext_irq(ext_irq),
  .crit_en(crit_en), .ext_en(ext_en), .crit_elev_en(crit_elev_en),
  .ext_elev_en(ext_elev_en), .pstat(pstat), .hi_pri(hi_pri),
  .state_q(state_q), .depth_q(depth_q)
);

// File: tb/irq_elev_ctrl_test.sv
`timescale 1ns/1ps
module irq_elev_ctrl_test;
  localparam logic [3:0] RFI = 4'b1010;

  logic clk = 1'b0;
  logic rst_n, crit_irq, ext_irq, crit_en, ext_en, crit_elev_en, ext_elev_en;
  logic [3:0] pstat;
  logic hi_pri;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // reference model state: 0 idle, 1 critical, 2 external
  int m_state = 0;
  int m_depth = 0;
  bit m_pc = 0, m_pe = 0;

  always #5 clk = ~clk;

  irq_elev_ctrl uut (
    .clk(clk), .rst_n(rst_n), .crit_irq(crit_irq), .ext_irq(ext_irq),
    .crit_en(crit_en), .ext_en(ext_en), .crit_elev_en(crit_elev_en),
    .ext_elev_en(ext_elev_en), .pstat(pstat), .hi_pri(hi_pri)
  );

  function automatic bit model_hi();
    return m_depth != 0;
  endfunction

  task automatic model_step();
    bit qc, qe, dc, de, inc, dec;
    int tgt, nd;
    if (!rst_n) begin
      m_state = 0; m_depth = 0; m_pc = 0; m_pe = 0;
      return;
    end
    qc = crit_irq & crit_en;  qe = ext_irq & ext_en;
    dc = qc & !m_pc;          de = qe & !m_pe;
    m_pc = qc;                m_pe = qe;
    inc = 0; tgt = m_state;
    dec = (pstat == RFI) && (m_depth != 0);
    if (m_state == 0) begin
      if (dc && crit_elev_en) begin inc = 1; tgt = 1; end
      else if (de && ext_elev_en) begin inc = 1; tgt = 2; end
    end else if (m_state == 2 && dc && m_depth < 3) begin
      inc = 1; tgt = 1;
    end
    nd = m_depth + int'(inc) - int'(dec);
    if (nd == 0) m_state = 0;
    else if (inc) m_state = tgt;
    else if (dec && m_state == 1) m_state = 2;
    m_depth = nd;
  endtask

  task automatic check(input string tag, input bit exp);
    checks++;
    if (hi_pri !== exp) begin
      fails++;
      $display("FAIL %s: hi_pri=%0b expected %0b at cycle %0d", tag, hi_pri, exp, cycles);
    end
  endtask

  // drive at negedge, update model, sample after the edge
  task automatic tick(input string tag);
    model_step();
    @(posedge clk);
    #1;
    check(tag, model_hi());
    @(negedge clk);
  endtask

  task automatic drv(input bit r, input bit c, input bit e, input bit ce, input bit ee,
                     input bit cv, input bit ev, input logic [3:0] ps, input string tag);
    rst_n = r; crit_irq = c; ext_irq = e; crit_en = ce; ext_en = ee;
    crit_elev_en = cv; ext_elev_en = ev; pstat = ps;
    tick(tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    // R1 reset state, with a critical request held through reset
    drv(0, 1, 0, 1, 1, 1, 1, 4'h0, "R1 reset low");
    drv(0, 1, 0, 1, 1, 1, 1, 4'h0, "R1 reset low");
    drv(1, 1, 0, 1, 1, 1, 1, 4'h0, "R1 held request seen after release");
    drv(1, 1, 0, 1, 1, 1, 1, RFI,  "R6 return drops");
    drv(1, 1, 0, 1, 1, 1, 1, 4'h0, "R11 held level no retrigger");
    drv(1, 0, 0, 1, 1, 1, 1, 4'h0, "R11 release");
    // R2 critical elevation and R5 hold
    drv(1, 1, 0, 1, 1, 1, 1, 4'h0, "R2 critical raises");
    drv(1, 0, 0, 1, 1, 1, 1, 4'hB, "R5 hold on 1011");
    drv(1, 0, 1, 1, 1, 1, 1, 4'h2, "R9 external ignored in critical");
    drv(1, 0, 0, 0, 0, 0, 0, 4'hF, "R10 enables cleared keeps high");
    drv(1, 0, 0, 1, 1, 1, 1, RFI,  "R6 return ends critical");
    drv(1, 0, 0, 1, 1, 1, 1, RFI,  "R6 return in idle ignored");
    // R3 external, R4 gating
    drv(1, 0, 1, 1, 0, 1, 1, 4'h0, "R4 ext_en low blocks");
    drv(1, 0, 0, 1, 1, 1, 1, 4'h0, "R4 idle");
    drv(1, 0, 1, 1, 1, 1, 0, 4'h0, "R4 ext_elev_en low blocks");
    drv(1, 0, 0, 1, 1, 1, 1, 4'h0, "R4 idle");
    drv(1, 1, 0, 0, 1, 1, 1, 4'h0, "R4 crit_en low blocks");
    drv(1, 0, 0, 1, 1, 1, 1, 4'h0, "R4 idle");
    drv(1, 0, 1, 1, 1, 1, 1, 4'h0, "R3 external raises");
    // R8 nesting
    drv(1, 1, 1, 1, 1, 0, 1, 4'h0, "R8 nested critical without elev bit");
    drv(1, 1, 1, 1, 1, 0, 1, RFI,  "R8 first return keeps high");
    drv(1, 0, 0, 1, 1, 1, 1, RFI,  "R8 second return drops");
    // R8 same-cycle cancel
    drv(1, 0, 1, 1, 1, 1, 1, 4'h0, "R3 external raises again");
    drv(1, 1, 1, 1, 1, 1, 1, RFI,  "R8 return cancels nested detection");
    drv(1, 1, 1, 1, 1, 1, 1, RFI,  "R8 final return drops");
    drv(1, 0, 0, 1, 1, 1, 1, 4'h0, "R8 idle");
    // R7 simultaneous
    drv(1, 1, 1, 1, 1, 1, 1, 4'h0, "R7 both raise");
    drv(1, 0, 1, 1, 1, 1, 1, 4'h0, "R7 critical low");
    drv(1, 1, 1, 1, 1, 1, 1, 4'h0, "R9 critical in critical ignored");
    drv(1, 1, 1, 1, 1, 1, 1, RFI,  "R7 one return drops");
    drv(1, 0, 0, 1, 1, 1, 1, 4'h0, "R7 idle");
    // R9 external in external ignored
    drv(1, 0, 1, 1, 1, 1, 1, 4'h0, "R3 raise");
    drv(1, 0, 0, 1, 1, 1, 1, 4'h0, "R9 ext low");
    drv(1, 0, 1, 1, 1, 1, 1, 4'h0, "R9 ext again ignored");
    drv(1, 0, 1, 1, 1, 1, 1, RFI,  "R9 one return drops");
    // R1 reset mid-elevation
    drv(1, 1, 0, 1, 1, 1, 1, 4'h0, "R2 raise");
    drv(0, 1, 0, 1, 1, 1, 1, 4'h0, "R1 reset while elevated");
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] ps;
      ps = (($urandom % 4) == 0) ? RFI : 4'($urandom);
      drv(($urandom % 300) != 0, ($urandom % 5) == 0 ? ~crit_irq : crit_irq,
          ($urandom % 4) == 0 ? ~ext_irq : ext_irq,
          ($urandom % 8) != 0, ($urandom % 8) != 0,
          ($urandom % 6) != 0, ($urandom % 6) != 0, ps, "R5 random model");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule